// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter that measures a selectable interval and acts when it runs out. Software programs a mode word that enables the watchdog, says whether expiry may reset the system, and picks one of twelve interval codes. The interval is counted in half-second units. Each unit is a parameterised number of timebase ticks, so a testbench can use short intervals while silicon uses a tick derived from a 24 MHz clock.

A running watchdog is refreshed through a control write. That write must set the restart bit and, in the same write, carry a fixed 12-bit key. A refresh without the key is dropped while the watchdog runs. While the watchdog is stopped, the restart bit alone reloads the count. On expiry the block does one of two things. With reset allowed, it drives a reset pulse of fixed length. With reset not allowed, it raises a sticky pending flag that drives an interrupt line through its own enable, so the block serves as an interval timer. In both cases the count reloads and the next interval starts at once.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode readback is 0x02 (enable 0, reset-allow 1, code 0). The interrupt enable, the pending flag, `sys_rst_o` and `irq_o` are all 0.
- R2: The mode write takes enable from data bit 0, reset-allow from bit 1 and the interval code from bits 6:3. Readback uses the same layout, with bit 2 reading 0. Codes 0 through 11 give 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 half-second units. Expiry occurs on the tick edge that completes TICKS_PER_HALF times that many ticks, counted from the edge after the enabling write or the last reload.
- R3: With an interval code of 12 or more, the counter does not advance and no expiry occurs. Selecting a valid code later starts the count from the held value.
- R4: A control write with data bit 0 set and bits 12:1 equal to 0xA57 reloads the count, so the next expiry comes one full interval after that write.
- R5: While the watchdog runs (enabled with a valid code), a control write whose key field is wrong, or whose bit 0 is clear, changes nothing.
- R6: While the watchdog is stopped, the count holds its value, and a control write with bit 0 set reloads the count whatever the key field holds.
- R7: On expiry with reset allowed, `sys_rst_o` goes high from the expiry edge for RST_CYCLES cycles. The count reloads, so expiries repeat once per interval.
- R8: On expiry with reset not allowed, no reset pulse is produced and the pending flag is set. `irq_o` is the pending flag gated by the interrupt enable, which is written from data bit 0.
- R9: A status write with data bit 0 set clears the pending flag, and one with bit 0 clear has no effect. If an expiry and a clearing write fall on the same edge, the flag stays set.
- R10: A valid restart write taken on the same edge as an expiry wins: no expiry happens on that edge, and the next one comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick; the counter advances only in cycles where it is high |
| wr_data_i | input | 13 | Write data shared by all write strobes |
| mode_wr_i | input | 1 | Write strobe for the mode word |
| ctrl_wr_i | input | 1 | Write strobe for the restart/key word |
| irqen_wr_i | input | 1 | Write strobe for the interrupt enable |
| irqsta_wr_i | input | 1 | Write strobe for the pending-flag clear |
| sys_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | Interval interrupt |
| rd_mode_o | output | 7 | Mode word readback |
| rd_irq_en_o | output | 1 | Interrupt enable readback |
| rd_irq_pend_o | output | 1 | Pending flag readback |

## Verification
Two pairs of functions can coincide on one edge: a keyed restart with an expiry, and a pending-flag clear with an expiry. The bench predicts each expiry edge from the interval table and times the write so that its strobe is taken exactly on that edge. A restart that wins must produce no reset pulse on that edge, which the scoreboard judges by receiving none and then receiving the next pulse a full interval later. A clear that loses must leave the pending flag readback at 1, with no new interrupt edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CODE_W    = 4;
    localparam int HALF_W    = 6;
    localparam int NUM_CODES = 12;
    localparam logic [11:0] RESTART_KEY = 12'hA57;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rst_allow;
        logic              en;
    } mode_t;
endpackage

// File: rtl/wdt_interval_decode.sv
module wdt_interval_decode
    import wdt_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [HALF_W-1:0] halves_o,
    output logic              valid_o
);
    // Non-linear table: linear steps of two below code 7, steps of four above.
    always_comb begin
        valid_o = (int'(code_i) < NUM_CODES);
        if (!valid_o) begin
            halves_o = '0;
        end else if (code_i == '0) begin
            halves_o = HALF_W'(1);
        end else if (code_i <= CODE_W'(6)) begin
            halves_o = HALF_W'({code_i, 1'b0});
        end else begin
            halves_o = HALF_W'(16) + HALF_W'({code_i - CODE_W'(7), 2'b00});
        end
    end
endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check
    import wdt_pkg::*;
(
    input  logic        ctrl_wr_i,
    input  logic [12:0] data_i,
    input  logic        running_i,
    output logic        reload_o
);
    logic key_ok;

    always_comb begin
        key_ok   = (data_i[12:1] == RESTART_KEY);
        // The key matters only while the counter is live.
        reload_o = ctrl_wr_i && data_i[0] && (!running_i || key_ok);
    end
endmodule

// File: rtl/wdt_pulse_stretch.sv
module wdt_pulse_stretch #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int TICKS_PER_HALF = 12_000_000,
    parameter int RST_CYCLES     = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic [12:0] wr_data_i,
    input  logic        mode_wr_i,
    input  logic        ctrl_wr_i,
    input  logic        irqen_wr_i,
    input  logic        irqsta_wr_i,
    output logic        sys_rst_o,
    output logic        irq_o,
    output logic [6:0]  rd_mode_o,
    output logic        rd_irq_en_o,
    output logic        rd_irq_pend_o
);
    localparam int PRE_W = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_HALF - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [HALF_W-1:0] half;
        mode_t             mode;
        logic              irq_en;
        logic              pend;
    } state_t;

    state_t st_d, st_q;

    logic [HALF_W-1:0] halves;
    logic              code_ok;
    logic              running;
    logic              reload;
    logic              pre_last;
    logic              half_last;
    logic              expire;
    logic              rst_fire;
    logic              irq_set;

    wdt_interval_decode u_decode (
        .code_i   (st_q.mode.code),
        .halves_o (halves),
        .valid_o  (code_ok)
    );

    assign running = st_q.mode.en && code_ok;

    wdt_key_check u_key (
        .ctrl_wr_i (ctrl_wr_i),
        .data_i    (wr_data_i),
        .running_i (running),
        .reload_o  (reload)
    );

    always_comb begin
        st_d      = st_q;
        pre_last  = (st_q.pre == PRE_LAST);
        half_last = (st_q.half == halves - HALF_W'(1));
        // A reload taken on the terminal edge suppresses that expiry.
        expire    = running && tick_i && pre_last && half_last && !reload;
        rst_fire  = expire && st_q.mode.rst_allow;
        irq_set   = expire && !st_q.mode.rst_allow;

        if (mode_wr_i) begin
            st_d.mode.en        = wr_data_i[0];
            st_d.mode.rst_allow = wr_data_i[1];
            st_d.mode.code      = wr_data_i[6:3];
        end
        if (irqen_wr_i) begin
            st_d.irq_en = wr_data_i[0];
        end

        if (reload) begin
            st_d.pre  = '0;
            st_d.half = '0;
        end else if (running && tick_i) begin
            if (pre_last) begin
                st_d.pre  = '0;
                st_d.half = half_last ? '0 : st_q.half + HALF_W'(1);
            end else begin
                st_d.pre  = st_q.pre + PRE_W'(1);
            end
        end

        if (irqsta_wr_i && wr_data_i[0]) begin
            st_d.pend = 1'b0;
        end
        if (irq_set) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.mode.rst_allow <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    wdt_pulse_stretch #(.CYCLES(RST_CYCLES)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (rst_fire),
        .pulse_o (sys_rst_o)
    );

    assign irq_o         = st_q.pend && st_q.irq_en;
    assign rd_mode_o     = {st_q.mode.code, 1'b0, st_q.mode.rst_allow, st_q.mode.en};
    assign rd_irq_en_o   = st_q.irq_en;
    assign rd_irq_pend_o = st_q.pend;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int RST_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_bit_i,
    input logic       irqsta_wr_i,
    input logic       sys_rst_o,
    input logic [6:0] rd_mode_o,
    input logic       rd_irq_pend_o
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else if (sys_rst_o) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= 0;
        end
    end

    // R7: the reset pulse lasts at least its configured length
    p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (hi_cnt >= RST_CYCLES));

    // R7: a pulse starts only after a cycle that was enabled, reset-allowed and valid
    p_rise_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(rd_mode_o[0] && rd_mode_o[1] && (rd_mode_o[6:3] < 4'd12)));

    // R3: an invalid code produces no expiry of either kind
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode_o[6:3] >= 4'd12) |=> (!$rose(sys_rst_o) && !$rose(rd_irq_pend_o)));

    // R8: with reset not allowed, no reset pulse begins
    p_no_rst_in_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mode_o[1] |=> !$rose(sys_rst_o));

    // R9: the pending flag falls only through a clearing write
    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_irq_pend_o && !(irqsta_wr_i && clr_bit_i)) |=> rd_irq_pend_o);
endmodule

bind keyed_watchdog wdt_checker #(.RST_CYCLES(RST_CYCLES)) u_wdt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_bit_i     (wr_data_i[0]),
    .irqsta_wr_i   (irqsta_wr_i),
    .sys_rst_o     (sys_rst_o),
    .rd_mode_o     (rd_mode_o),
    .rd_irq_pend_o (rd_irq_pend_o)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int TPH = 4;
    localparam int RST = 3;
    localparam logic [11:0] KEY = 12'hA57;

    typedef struct {
        int    kind;   // 0 reset pulse, 1 interrupt edge
        int    at;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic [12:0] wr_data_i = '0;
    logic        mode_wr_i = 1'b0;
    logic        ctrl_wr_i = 1'b0;
    logic        irqen_wr_i = 1'b0;
    logic        irqsta_wr_i = 1'b0;
    logic        sys_rst_o, irq_o, rd_irq_en_o, rd_irq_pend_o;
    logic [6:0]  rd_mode_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    int   rst_rises = 0;
    int   irq_rises = 0;
    int   hi_len = 0;
    logic rst_prev = 1'b0;
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_watchdog #(.TICKS_PER_HALF(TPH), .RST_CYCLES(RST)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_data_i(wr_data_i),
        .mode_wr_i(mode_wr_i), .ctrl_wr_i(ctrl_wr_i), .irqen_wr_i(irqen_wr_i),
        .irqsta_wr_i(irqsta_wr_i), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
        .rd_mode_o(rd_mode_o), .rd_irq_en_o(rd_irq_en_o), .rd_irq_pend_o(rd_irq_pend_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int halves(input int code);
        case (code)
            0: return 1;   1: return 2;   2: return 4;   3: return 6;
            4: return 8;   5: return 10;  6: return 12;  7: return 16;
            8: return 20;  9: return 24;  10: return 28; 11: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int period(input int code);
        return TPH * halves(code);
    endfunction

    task automatic push(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    // Drives one write; c is the last edge before the strobe is taken.
    task automatic wr(input int which, input logic [12:0] d, output int c);
        @(negedge clk);
        wr_data_i = d;
        mode_wr_i   = (which == 0);
        ctrl_wr_i   = (which == 1);
        irqen_wr_i  = (which == 2);
        irqsta_wr_i = (which == 3);
        c = cyc;
        @(negedge clk);
        mode_wr_i = 1'b0; ctrl_wr_i = 1'b0; irqen_wr_i = 1'b0; irqsta_wr_i = 1'b0;
    endtask

    function automatic logic [12:0] mode_word(input bit en, input bit ra, input int code);
        return {6'd0, 4'(code), 1'b0, ra, en};
    endfunction

    task automatic set_mode(input bit en, input bit ra, input int code, output int c);
        wr(0, mode_word(en, ra, code), c);
    endtask

    // Stopped reload (R6) followed by an enabling write.
    task automatic fresh_start(input bit ra, input int code, output int c);
        int t;
        set_mode(0, ra, code, t);
        wr(1, 13'h0001, t);
        set_mode(1, ra, code, c);
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic pop_expect(input int kind);
        if (q.size() == 0 || q[0].kind != kind) begin
            checks++;
            errors++;
            $display("FAIL R5 R10 R3 unexpected event kind %0d: actual cycle %0d expected none", kind, cyc);
        end else begin
            exp_t e;
            e = q.pop_front();
            check(e.at == cyc, e.req, "event cycle", cyc, e.at);
        end
    endtask

    // Monitor: scoreboard consumer
    always @(negedge clk) begin
        if (rst_n) begin
            if (sys_rst_o && !rst_prev) begin
                rst_rises++;
                pop_expect(0);
            end
            if (sys_rst_o) begin
                hi_len++;
            end else if (rst_prev) begin
                check(hi_len == RST, "R7", "reset pulse width", hi_len, RST);
                hi_len = 0;
            end
            if (irq_o && !irq_prev) begin
                irq_rises++;
                pop_expect(1);
            end
            rst_prev = sys_rst_o;
            irq_prev = irq_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 R10: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c, c2, d, e, n, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rd_mode_o == 7'h02, "R1", "mode readback", int'(rd_mode_o), 2);
        check(rd_irq_en_o == 1'b0, "R1", "irq enable", int'(rd_irq_en_o), 0);
        check(rd_irq_pend_o == 1'b0, "R1", "pending", int'(rd_irq_pend_o), 0);
        check(sys_rst_o == 1'b0 && irq_o == 1'b0, "R1", "outputs", int'({sys_rst_o, irq_o}), 0);

        // R2 R7: code 0 with repeat
        fresh_start(1, 0, c);
        check(rd_mode_o == 7'h03, "R2", "mode readback after write", int'(rd_mode_o), 3);
        push(0, c + 1 + period(0), "R2");
        push(0, c + 1 + 2 * period(0), "R7");
        wait_until(c + 1 + 2 * period(0));
        set_mode(0, 1, 0, d);
        repeat (RST + 2) @(negedge clk);

        // R2 other codes
        foreach (halves_codes[i]) begin
            fresh_start(1, halves_codes[i], c);
            check(rd_mode_o == 7'(mode_word(1, 1, halves_codes[i])), "R2", "mode readback",
                  int'(rd_mode_o), int'(mode_word(1, 1, halves_codes[i])));
            push(0, c + 1 + period(halves_codes[i]), "R2");
            wait_until(c + 2 + period(halves_codes[i]));
            set_mode(0, 1, halves_codes[i], d);
            repeat (RST + 2) @(negedge clk);
        end

        // R3 invalid codes
        base = rst_rises;
        fresh_start(1, 12, c);
        repeat (150) @(negedge clk);
        set_mode(1, 1, 15, c);
        repeat (150) @(negedge clk);
        check(rst_rises == base, "R3", "no expiry on invalid code", rst_rises - base, 0);
        set_mode(1, 1, 0, c);
        push(0, c + 1 + period(0), "R3");
        wait_until(c + 2 + period(0));
        set_mode(0, 1, 0, d);
        repeat (RST + 2) @(negedge clk);

        // R4 keyed restart on a running watchdog
        fresh_start(1, 3, c);
        wait_until(c + 10);
        wr(1, {KEY, 1'b1}, c2);
        push(0, c2 + 1 + period(3), "R4");
        wait_until(c2 + 2 + period(3));
        set_mode(0, 1, 3, d);
        repeat (RST + 2) @(negedge clk);

        // R5 wrong key and missing restart bit while running
        fresh_start(1, 3, c);
        wait_until(c + 8);
        wr(1, {12'h123, 1'b1}, c2);
        wr(1, {KEY, 1'b0}, c2);
        push(0, c + 1 + period(3), "R5");
        wait_until(c + 2 + period(3));
        set_mode(0, 1, 3, d);
        repeat (RST + 2) @(negedge clk);

        // R6 count holds while stopped
        fresh_start(1, 3, c);
        wait_until(c + 9);
        set_mode(0, 1, 3, d);
        repeat (20) @(negedge clk);
        set_mode(1, 1, 3, e);
        n = period(3) - (d - c);
        push(0, e + 1 + n, "R6");
        wait_until(e + 2 + n);
        set_mode(0, 1, 3, d);
        repeat (RST + 2) @(negedge clk);

        // R6 stopped reload without key
        fresh_start(1, 3, c);
        wait_until(c + 10);
        set_mode(0, 1, 3, d);
        repeat (10) @(negedge clk);
        wr(1, 13'h0001, c2);
        set_mode(1, 1, 3, e);
        push(0, e + 1 + period(3), "R6");
        wait_until(e + 2 + period(3));
        set_mode(0, 1, 3, d);
        repeat (RST + 2) @(negedge clk);

        // R10 restart on the expiry edge
        fresh_start(1, 0, c);
        wait_until(c + period(0) - 1);
        wr(1, {KEY, 1'b1}, c2);
        check(c2 == c + period(0), "R10", "restart aligned to expiry edge", c2, c + period(0));
        push(0, c2 + 1 + period(0), "R10");
        wait_until(c2 + 2 + period(0));
        set_mode(0, 1, 0, d);
        repeat (RST + 2) @(negedge clk);

        // R8 interval mode
        base = rst_rises;
        wr(2, 13'h0001, d);
        check(rd_irq_en_o == 1'b1, "R8", "irq enable readback", int'(rd_irq_en_o), 1);
        fresh_start(0, 0, c);
        e = c + 1 + period(0);
        push(1, e, "R8");
        wait_until(e + 1);
        check(rd_irq_pend_o == 1'b1, "R8", "pending after expiry", int'(rd_irq_pend_o), 1);

        // R9 clear between expiries, then clear on the expiry edge
        push(1, e + period(0), "R9");
        wr(3, 13'h0001, d);
        check(rd_irq_pend_o == 1'b0, "R9", "pending after clear", int'(rd_irq_pend_o), 0);
        wait_until(e + 2 * period(0) - 2);
        wr(3, 13'h0001, d);
        check(d + 1 == e + 2 * period(0), "R9", "clear aligned to expiry", d + 1, e + 2 * period(0));
        check(rd_irq_pend_o == 1'b1, "R9", "set wins over clear", int'(rd_irq_pend_o), 1);
        set_mode(0, 0, 0, d);
        check(rst_rises == base, "R8", "no reset pulse in interval mode", rst_rises - base, 0);

        // R8 gating, R9 zero write
        wr(2, 13'h0000, d);
        check(irq_o == 1'b0 && rd_irq_pend_o == 1'b1, "R8", "irq gated off",
              int'({irq_o, rd_irq_pend_o}), 1);
        wr(3, 13'h0000, d);
        check(rd_irq_pend_o == 1'b1, "R9", "zero write keeps pending", int'(rd_irq_pend_o), 1);
        wr(3, 13'h0001, d);
        check(rd_irq_pend_o == 1'b0, "R9", "clear while stopped", int'(rd_irq_pend_o), 0);

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R2", "all expected events seen", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    int halves_codes[4] = '{1, 6, 7, 11};
endmodule